// File: doc/BRIEF.md
# Programmable Wait State Generator

This block stretches read accesses to one slow device by holding a processor's ready request low for a chosen number of clocks. It watches an active-low read strobe that outside logic has already gated with the device's address decode. While that strobe is inactive, a short chain of flops is held clear. Once the strobe goes active, the chain fills with ones, one stage per clock. A 3-bit wait count, which stands in for a board jumper, picks which stage of the chain drives the ready request.

The ready request is the chosen stage ORed with the strobe. It is therefore high whenever no read is in progress. During a read it stays low for exactly the selected number of clock edges and then rises. When the device-select input is low, the output is forced high, so the generator never stalls accesses to other devices. The wait count is captured only while the strobe is inactive. A change made during a read therefore applies from the next bus cycle. Stage 0 is a constant one, so a count of zero inserts no wait.

Top module: `wait_state_gen`

## Requirements
- R1: An active (low) rst_n clears the chain and sets the captured wait count to 0. readyOut is then high, even with the strobe active and devSel high. The count stays 0 until the strobe has been sampled inactive at a clock edge.
- R2: While rdStrobeN is high (inactive), readyOut is high.
- R3: While devSel is low, readyOut is high for any strobe level and wait count.
- R4: With a captured wait count n from 1 to 6, devSel high and rdStrobeN low, readyOut is low until n rising clock edges have sampled the strobe low. It is then high until the strobe is released.
- R5: With a captured wait count of 0, readyOut is high from the moment the strobe goes active.
- R6: With a captured wait count of 7, readyOut is low for 7 edges and then stays high however long the strobe is held.
- R7: waitSel is captured at each rising edge that samples rdStrobeN high. A change while the strobe is active has no effect until the next bus cycle.
- R8: A single edge that samples the strobe inactive clears the chain, so the next active strobe counts the full wait count again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rdStrobeN | input | 1 | Gated read strobe, active low |
| devSel | input | 1 | High while the slow device is addressed |
| waitSel | input | 3 | Number of wait states, 0 to 7 |
| readyOut | output | 1 | Ready request, high means ready |

## Verification
A wrong chain stage or a wrong captured count shows up directly at readyOut. The ready edge moves by one clock during the first read that uses that count. A chain that is not cleared shows up on the next bus cycle: ready rises early or is high at once. A count that follows waitSel during a read makes ready rise at the wrong edge in the same cycle. The bench model and the checker therefore compare readyOut on every clock, so each such fault appears within one bus cycle.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  // Strobes issued by the control to the tap chain datapath
  typedef struct packed {
    logic clearChain;
    logic shiftChain;
    logic loadSel;
  } wsgCtrl_t;
endpackage

// File: rtl/wsg_datapath.sv
module wsg_datapath
  import wsg_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  localparam int SEL_W = $clog2(CHAIN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wsgCtrl_t         ctrl,
  input  logic [SEL_W-1:0] waitSel,
  output logic             tapBit
);
  // stage 0 is a constant one; real flops hold stages 1..CHAIN_LEN-1
  logic [CHAIN_LEN-2:0] chain;
  logic [SEL_W-1:0]     selReg;
  logic [CHAIN_LEN-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else if (ctrl.clearChain) begin
      chain <= '0;
    end else if (ctrl.shiftChain) begin
      chain <= {chain[CHAIN_LEN-3:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selReg <= '0;
    end else if (ctrl.loadSel) begin
      selReg <= waitSel;
    end
  end

  genvar i;
  generate
    for (i = 0; i < CHAIN_LEN; i++) begin : g_tap
      if (i == 0) begin : g_first
        assign taps[i] = 1'b1;
      end else begin : g_stage
        assign taps[i] = chain[i-1];
      end
    end
  endgenerate

  assign tapBit = taps[selReg];
endmodule

// File: rtl/wsg_control.sv
module wsg_control
  import wsg_pkg::*;
(
  input  logic     rdStrobeN,
  input  logic     devSel,
  input  logic     tapBit,
  output wsgCtrl_t ctrl,
  output logic     readyOut
);
  always_comb begin
    ctrl.clearChain = rdStrobeN;
    ctrl.shiftChain = !rdStrobeN;
    ctrl.loadSel    = rdStrobeN;
  end

  assign readyOut = !devSel || rdStrobeN || tapBit;
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
  import wsg_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  localparam int SEL_W = $clog2(CHAIN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdStrobeN,
  input  logic             devSel,
  input  logic [SEL_W-1:0] waitSel,
  output logic             readyOut
);
  wsgCtrl_t ctrl;
  logic     tapBit;

  wsg_control u_ctrl (
    .rdStrobeN (rdStrobeN),
    .devSel    (devSel),
    .tapBit    (tapBit),
    .ctrl      (ctrl),
    .readyOut  (readyOut)
  );

  wsg_datapath #(.CHAIN_LEN(CHAIN_LEN)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .waitSel (waitSel),
    .tapBit  (tapBit)
  );
endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
  parameter int CHAIN_LEN = 8,
  localparam int SEL_W = $clog2(CHAIN_LEN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rdStrobeN,
  input logic             devSel,
  input logic [SEL_W-1:0] waitSel,
  input logic             readyOut
);
  // independent edge counter of the active strobe and captured count
  logic [SEL_W:0]   edgeCnt;
  logic [SEL_W-1:0] heldSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edgeCnt <= '0;
      heldSel <= '0;
    end else if (rdStrobeN) begin
      edgeCnt <= '0;
      heldSel <= waitSel;
    end else if (edgeCnt < (SEL_W+1)'(CHAIN_LEN)) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  a_r2_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rdStrobeN |-> readyOut);

  a_r3_unselected_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !devSel |-> readyOut);

  a_r4_wait_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdStrobeN && devSel) |-> (readyOut == (edgeCnt >= {1'b0, heldSel})));

  a_r6_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdStrobeN && devSel && readyOut) |=> (rdStrobeN || !devSel || readyOut));

  a_r5_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdStrobeN && devSel && heldSel == '0) |-> readyOut);
endmodule

bind wait_state_gen wsg_checker #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rdStrobeN (rdStrobeN),
  .devSel    (devSel),
  .waitSel   (waitSel),
  .readyOut  (readyOut)
);

// File: tb/tb_wait_state_gen.sv
`timescale 1ns/1ps
module tb_wait_state_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rdStrobeN = 1'b1;
  logic       devSel = 1'b1;
  logic [2:0] waitSel = 3'd0;
  logic       readyOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference: edges since strobe went active, captured count
  int edgesLow = 0;
  int heldCount = 0;

  always #4 clk = ~clk;

  wait_state_gen dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdStrobeN (rdStrobeN),
    .devSel    (devSel),
    .waitSel   (waitSel),
    .readyOut  (readyOut)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edgesLow = 0;
      heldCount = 0;
    end else if (rdStrobeN) begin
      edgesLow = 0;
      heldCount = int'(waitSel);
    end else begin
      edgesLow = edgesLow + 1;
    end
  end

  task automatic step(input logic rst, input logic strobeN, input logic sel,
                      input int ws, input string tag);
    logic expReady;
    @(negedge clk);
    rst_n = rst;
    rdStrobeN = strobeN;
    devSel = sel;
    waitSel = 3'(ws);
    #1;
    expReady = !devSel || rdStrobeN || (edgesLow >= heldCount);
    checks++;
    if (readyOut !== expReady) begin
      failures++;
      $display("FAIL %s readyOut actual=%b expected=%b (edges=%0d count=%0d)",
               tag, readyOut, expReady, edgesLow, heldCount);
    end
  endtask

  // idle phase then an active read of the given length
  task automatic busCycle(input int ws, input int activeLen, input logic sel,
                          input string tag);
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, sel, ws, "R2");
    for (int i = 0; i < activeLen; i++) step(1'b1, 1'b0, sel, ws, tag);
  endtask

  initial begin
    // R1: reset with strobe active and a nonzero count requested
    step(1'b0, 1'b0, 1'b1, 5, "R1");
    step(1'b0, 1'b0, 1'b1, 5, "R1");
    step(1'b1, 1'b0, 1'b1, 5, "R1");
    step(1'b1, 1'b0, 1'b1, 5, "R1");

    // R4, R5, R6: every wait count
    for (int n = 0; n < 8; n++) begin
      if (n == 0)      busCycle(n, 4, 1'b1, "R5");
      else if (n == 7) busCycle(n, 20, 1'b1, "R6");
      else             busCycle(n, n + 3, 1'b1, "R4");
    end

    // R3: device not selected
    busCycle(4, 8, 1'b0, "R3");
    busCycle(0, 3, 1'b0, "R3");

    // R7: count changed during an active read has no effect until next cycle
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 1'b1, 2, "R2");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, 6, "R7");
    for (int i = 0; i < 9; i++) step(1'b1, (i < 1), 1'b1, 6, "R7");

    // R8: one idle edge restarts the count
    busCycle(5, 3, 1'b1, "R8");
    step(1'b1, 1'b1, 1'b1, 5, "R8");
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b1, 5, "R8");

    // R3 mid-read: deselect during waits, then reselect
    busCycle(6, 2, 1'b1, "R4");
    step(1'b1, 1'b0, 1'b0, 6, "R3");
    step(1'b1, 1'b0, 1'b0, 6, "R3");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 6, "R4");

    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 1'b1, 0, "R2");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule